// File: doc/BRIEF.md
# External Interrupt Cause Latch

This block watches eight external interrupt pins and keeps one cause flag per pin. Each pin is brought into the clock domain through two flip-flops. A two-bit mode field then decides which condition on the pin counts as an event: low level, high level, rising edge or falling edge. An event sets that channel's flag. The flag stays set until software writes a 0 to it, or until a data-transfer service signals that it has finished the transfer for that channel.

The flags are ANDed with per-channel enable bits. The OR of the results is registered and drives a single interrupt request to the CPU. Software reaches three registers over a small synchronous bus: flags at address 0, enables at address 1, and the packed mode fields at address 2. Reads are combinational on the address.

Top module: `ext_irq_latch`

## Requirements
- R1: After reset the flags and enables read 0, the mode register reads 16'hAAAA (rising edge on every channel), and irq_o is 0.
- R2: A pin transition passes two synchroniser flops. If the pin changes before clock edge k, the flag reads 1 after edge k+2 and not earlier. A flag never sets without a qualifying event.
- R3: The mode of channel n sits in bits [2n+1:2n] of address 2. The codes are: 00 low level, 01 high level, 10 rising edge, 11 falling edge.
- R4: A write to address 0 clears each flag whose wdata bit in [7:0] is 0. A flag whose wdata bit is 1 keeps its value.
- R5: A pulse on svc_done_i[n] clears flag n on that edge, unless an event for channel n occurs in the same cycle.
- R6: If a set event and a clear (a write of 0 or a service pulse) fall in the same cycle, the flag ends at 1.
- R7: In a level mode, a flag cleared while its level is still present reads 1 again right after the clearing edge.
- R8: irq_o is a register holding the OR of (flag AND enable) from the previous cycle. It drops in the cycle after the last enabled flag clears. The enables are bits [7:0] of address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 8 | Asynchronous external interrupt pins |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 flags, 1 enables, 2 modes |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| svc_done_i | input | 8 | Per-channel transfer-complete clear pulse |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A wrong flag or enable state shows up in two places. It appears on rdata_o as soon as address 0 or 1 is read. It also appears on irq_o exactly one cycle later, so a lost event, a stuck flag or a clear that fails to win over a set gives a mismatch within one or two cycles. A wrong synchroniser depth or edge history moves the time the flag appears by one cycle, or sets the flag for the wrong polarity. Those faults therefore show up on the first directed pin transition, and again during the random traffic.

// File: rtl/ext_irq_latch.sv
module ext_irq_latch #(
  parameter int N = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  pin_i,
  input  logic        wr_i,
  input  logic [1:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  input  logic [7:0]  svc_done_i,
  output logic        irq_o
);
  localparam int MW = 2 * N;

  logic [N-1:0]  s1, s2, prev;
  logic [N-1:0]  flag, en, evt, clr;
  logic [MW-1:0] mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      prev <= '0;
    end else begin
      s1 <= pin_i[N-1:0];
      s2 <= s1;
      prev <= s2;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      case (mode[2*i +: 2])
        2'b00:   evt[i] = ~s2[i];
        2'b01:   evt[i] = s2[i];
        2'b10:   evt[i] = s2[i] & ~prev[i];
        default: evt[i] = ~s2[i] & prev[i];
      endcase
    end
  end

  assign clr = ((wr_i && addr_i == 2'd0) ? ~wdata_i[N-1:0] : '0) | svc_done_i[N-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= '0;
      en    <= '0;
      mode  <= {N{2'b10}};
      irq_o <= 1'b0;
    end else begin
      flag  <= (flag & ~clr) | evt;
      irq_o <= |(flag & en);
      if (wr_i && addr_i == 2'd1) en <= wdata_i[N-1:0];
      if (wr_i && addr_i == 2'd2) mode <= wdata_i[MW-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      2'd0: rdata_o[N-1:0] = flag;
      2'd1: rdata_o[N-1:0] = en;
      2'd2: rdata_o[MW-1:0] = mode;
      default: rdata_o = '0;
    endcase
  end

  assert_irq_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag & en)) |=> irq_o);
  assert_irq_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flag & en)) |=> !irq_o);
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flag & $past(evt)) == $past(evt)));
  assert_write_one_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == 2'd0 && svc_done_i == '0) |=>
      ((flag & $past(flag & wdata_i[N-1:0])) == $past(flag & wdata_i[N-1:0])));
  assert_svc_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(svc_done_i[N-1:0] & ~evt)) |=> ((flag & $past(svc_done_i[N-1:0] & ~evt)) == '0));
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag & ~$past(flag) & ~$past(evt)) == '0));
endmodule

// File: tb/ext_irq_latch_tb.sv
module ext_irq_latch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_i = '0;
  logic        wr_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [7:0]  svc_done_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;

  logic [7:0]  m_s1 = '0, m_s2 = '0, m_prev = '0, m_flag = '0, m_en = '0;
  logic [15:0] m_mode = 16'hAAAA;
  logic        m_irq = 1'b0;

  always #10 clk = ~clk;

  ext_irq_latch dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .svc_done_i(svc_done_i), .irq_o(irq_o)
  );

  function automatic logic [7:0] events(logic [7:0] s, logic [7:0] p, logic [15:0] md);
    logic [7:0] e;
    for (int i = 0; i < 8; i++) begin
      case (md[2*i +: 2])
        2'b00:   e[i] = !s[i];
        2'b01:   e[i] = s[i];
        2'b10:   e[i] = s[i] && !p[i];
        default: e[i] = !s[i] && p[i];
      endcase
    end
    return e;
  endfunction

  function automatic logic [15:0] model_read(logic [1:0] a);
    case (a)
      2'd0: return {8'h00, m_flag};
      2'd1: return {8'h00, m_en};
      2'd2: return m_mode;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic [7:0] e, c;
    e = events(m_s2, m_prev, m_mode);
    c = svc_done_i | ((wr_i && addr_i == 2'd0) ? ~wdata_i[7:0] : 8'h00);
    m_irq = |(m_flag & m_en);
    m_flag = (m_flag & ~c) | e;
    if (wr_i && addr_i == 2'd1) m_en = wdata_i[7:0];
    if (wr_i && addr_i == 2'd2) m_mode = wdata_i;
    m_prev = m_s2;
    m_s2 = m_s1;
    m_s1 = pin_i;
  endtask

  task automatic cycle(string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(req, rdata_o, model_read(addr_i));
    check("R8", {15'd0, irq_o}, {15'd0, m_irq});
  endtask

  task automatic idle();
    wr_i = 1'b0; svc_done_i = '0; addr_i = 2'd0; wdata_i = '0;
  endtask

  task automatic write(logic [1:0] a, logic [15:0] d, string req);
    wr_i = 1'b1; addr_i = a; wdata_i = d; svc_done_i = '0;
    cycle(req);
    idle();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    addr_i = 2'd0; #1 check("R1", rdata_o, 16'h0000);
    addr_i = 2'd1; #1 check("R1", rdata_o, 16'h0000);
    addr_i = 2'd2; #1 check("R1", rdata_o, 16'hAAAA);
    check("R1", {15'd0, irq_o}, 16'h0000);
    idle();

    // R2 synchroniser latency, rising mode on channel 0
    write(2'd1, 16'h00FF, "R8");
    pin_i = 8'h01;
    cycle("R2");
    check("R2", rdata_o, 16'h0000);
    cycle("R2");
    check("R2", rdata_o, 16'h0000);
    cycle("R2");
    check("R2", rdata_o, 16'h0001);
    cycle("R8");
    check("R8", {15'd0, irq_o}, 16'h0001);

    // R4 write one keeps, write zero clears
    write(2'd0, 16'h00FF, "R4");
    check("R4", rdata_o, 16'h0001);
    write(2'd0, 16'h00FE, "R4");
    check("R4", rdata_o, 16'h0000);
    cycle("R8");
    check("R8", {15'd0, irq_o}, 16'h0000);

    // R3 falling mode on channel 0: pin goes low
    write(2'd2, 16'hAAAB, "R3");
    pin_i = 8'h00;
    repeat (3) cycle("R3");
    check("R3", rdata_o, 16'h0001);

    // R5 service clear
    svc_done_i = 8'h01;
    cycle("R5");
    check("R5", rdata_o, 16'h0000);
    idle();

    // R6 and R7: high-level mode on channel 1, level held, clears lose
    write(2'd2, 16'hAAA6, "R3");
    pin_i = 8'h02;
    repeat (3) cycle("R3");
    check("R3", rdata_o, 16'h0002);
    write(2'd0, 16'h0000, "R7");
    check("R7", rdata_o, 16'h0002);
    svc_done_i = 8'h02;
    cycle("R6");
    check("R6", rdata_o, 16'h0002);
    idle();
    pin_i = 8'h00;
    repeat (3) cycle("R7");
    write(2'd0, 16'h0000, "R4");
    check("R4", rdata_o, 16'h0000);

    // random traffic against the bench model
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom();
      if (r[2:0] == 3'd0) pin_i = $urandom();
      else if (r[3]) pin_i = pin_i ^ (8'h01 << r[6:4]);
      wr_i = (r[9:7] == 3'd0);
      addr_i = r[11:10];
      wdata_i = $urandom();
      if (wr_i && addr_i == 2'd2 && r[12]) wdata_i = 16'hAAAA ^ {8'h00, r[20:13]};
      svc_done_i = (r[23:21] == 3'd0) ? (8'h01 << r[26:24]) : 8'h00;
      cycle(addr_i == 2'd0 ? "R4" : (addr_i == 2'd1 ? "R8" : "R3"));
    end
    idle();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule